// File: doc/BRIEF.md
# Dual-Strobe Byte-Lane DRAM Control Logic

This block is a clock-sampled model of the control side of a 16-bit dynamic memory with two column strobes, one per byte. Each clock edge samples the active-low row strobe, the two column strobes, the write enable, the output enable, the multiplexed address and the input data. Edges on these strobes are found by comparing each sample with the one before. The model holds a small parameterized storage array. It merges the two column strobes into one internal strobe and steers writes to byte lanes. It tells early writes apart from late writes and read-modify-write cycles. It also keeps read data on the bus after the column strobe rises (extended data out), and it applies the enable rules that switch each output byte lane on and off.

A controller, or a bench that plays the role of one, opens a row by lowering the row strobe. It then runs one or more column accesses in page mode, lowering one or both column strobes per access, and closes the row by raising every strobe. The block drives the data bus through a per-lane output enable. Analog timing is not modelled. An event takes effect on the clock edge that samples it.

Top module: `dual_strobe_dram_ctl`

## Requirements
- R1: The internal column strobe becomes active on the first sampled fall of either lane strobe and becomes inactive only when both are high again. A lane strobe that rises and falls while the other stays low does not start a new access, and the column address is not latched again.
- R2: The lower strobe (casl_n) gates data bits 7:0 and the upper strobe (cash_n) gates bits 15:8. dq_en bit 0 is the lower lane and bit 1 is the upper lane. Both strobes low gives a full-word access.
- R3: The row address is taken from addr on the edge that first sees ras_n low. The column address is taken from addr on the edge that starts an access, and only once ras_n has been low for at least one earlier sample.
- R4: If we_n is low when an access starts, the access is an early write. Each selected lane stores dq_in as sampled on the edge where its strobe falls.
- R5: During an early write dq_en stays 0 whatever the level of oe_n.
- R6: In a read access with oe_n high, a fall of we_n while the internal strobe is active is a late write. It stores dq_in into the lanes whose strobes are low at that edge.
- R7: A fall of we_n during a read access while oe_n is low stores nothing. The enabled lanes keep driving the data that was read.
- R8: Read data stays on the bus after the internal strobe rises, as long as ras_n and oe_n stay low. Pulsing oe_n high while the internal strobe is low returns the same data when oe_n goes low again.
- R9: dq_en falls to 0 once ras_n and both column strobes are high. A high on oe_n while the internal strobe is inactive also turns the outputs off until the next read access.
- R10: A fall of we_n while the internal strobe is inactive turns the outputs off until the next read access starts.
- R11: If the internal strobe is already low when ras_n falls, no access starts and the output lanes and data are held.
- R12: Both lanes work in one mode per strobe period. A lane that joins an early write while we_n is high is not written and not driven. A lane that joins after a late write is ignored.
- R13: dq_en and dq_out change one clock edge after the inputs that cause the change are sampled, except that oe_n high masks dq_en at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower-lane column strobe, active low |
| cash_n | input | 1 | Upper-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 2*LANE_W | Data from the bus |
| dq_out | output | 2*LANE_W | Data to the bus |
| dq_en | output | 2 | Per-lane output drive enable |

## Verification
The risky overlaps are a lane strobe edge falling on the same sample as a write-enable or output-enable event inside one strobe period. One case is a lane that joins an early write or a late write just as the mode has been fixed. Another is a fall of we_n in a read while oe_n is either low or high. Directed sequences set these edges on neighbouring or identical samples. The bench then judges the result in two ways. It checks dq_en and dq_out one edge later, and it reads the location back afterwards to show whether a byte was or was not stored. Random page sequences of reads, byte early writes and late writes are compared with a reference array kept by the bench.

// File: rtl/dual_strobe_dram_ctl.sv
module dual_strobe_dram_ctl #(
  parameter int ADDR_W = 4,
  parameter int ROW_W  = 4,
  parameter int COL_W  = 3,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ras_n,
  input  logic                  casl_n,
  input  logic                  cash_n,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANE_W-1:0]   dq_in,
  output logic [2*LANE_W-1:0]   dq_out,
  output logic [1:0]            dq_en
);
  localparam int DQ_W  = 2 * LANE_W;
  localparam int IDX_W = ROW_W + COL_W;
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [1:0] {M_IDLE, M_RD, M_EW, M_LW} mode_t;

  logic [DQ_W-1:0]  mem [DEPTH];
  logic [ROW_W-1:0] row_r;
  logic [COL_W-1:0] col_r;
  logic [DQ_W-1:0]  q_r;
  logic [1:0]       drv, lane_q;
  logic             ras_q, we_q;
  mode_t            mode_r, mode_n;

  logic [1:0]       lane_now, lane_fall, wr_lane, ld_lane, drv_n;
  logic             cas_any, cas_q, acc_ok, start, we_fall, late_wr;
  logic [COL_W-1:0] col_now;
  logic [DQ_W-1:0]  rd_word;

  assign lane_now  = {~cash_n, ~casl_n};
  assign lane_fall = lane_now & ~lane_q;
  assign cas_any   = |lane_now;
  assign cas_q     = |lane_q;
  assign acc_ok    = ~ras_n & ~ras_q;
  assign start     = acc_ok & cas_any & ~cas_q;
  assign we_fall   = ~we_n & we_q;
  assign col_now   = start ? addr[COL_W-1:0] : col_r;
  assign rd_word   = mem[{row_r, col_now}];
  assign late_wr   = (mode_r == M_RD) & cas_any & ~ras_n & we_fall & oe_n;

  always_comb begin
    wr_lane = 2'b00;
    ld_lane = 2'b00;
    mode_n  = mode_r;
    if (!cas_any) begin
      mode_n = M_IDLE;
    end else if (start) begin
      if (!we_n) begin
        wr_lane = lane_now;
        mode_n  = M_EW;
      end else begin
        ld_lane = lane_now;
        mode_n  = M_RD;
      end
    end else if (late_wr) begin
      wr_lane = lane_now;
      mode_n  = M_LW;
    end else if (!ras_n) begin
      if (mode_r == M_EW && !we_n)
        wr_lane = lane_fall;
      else if (mode_r == M_RD && we_n)
        ld_lane = lane_fall;
    end
  end

  always_comb begin
    if (ras_n && !cas_any)
      drv_n = 2'b00;
    else if (start && !we_n)
      drv_n = 2'b00;
    else if (!cas_any && (oe_n || we_fall))
      drv_n = 2'b00;
    else if (start)
      drv_n = ld_lane;
    else
      drv_n = drv | ld_lane;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      we_q   <= 1'b1;
      lane_q <= 2'b00;
      row_r  <= '0;
      col_r  <= '0;
      q_r    <= '0;
      drv    <= 2'b00;
      mode_r <= M_IDLE;
    end else begin
      ras_q  <= ras_n;
      we_q   <= we_n;
      lane_q <= lane_now;
      mode_r <= mode_n;
      drv    <= drv_n;
      if (!ras_n && ras_q) row_r <= addr[ROW_W-1:0];
      if (start) col_r <= addr[COL_W-1:0];
      for (int i = 0; i < 2; i++)
        if (ld_lane[i]) q_r[i*LANE_W +: LANE_W] <= rd_word[i*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++)
      if (rst_n && wr_lane[i])
        mem[{row_r, col_now}][i*LANE_W +: LANE_W] <= dq_in[i*LANE_W +: LANE_W];
  end

  assign dq_out = q_r;
  assign dq_en  = drv & {2{~oe_n}};

  AST_EW_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n) (mode_r == M_EW) |-> (dq_en == 2'b00)); // R5
  AST_OFF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n) (ras_n && !cas_any) |=> (drv == 2'b00)); // R9
  AST_EDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ras_n && !cas_any && !oe_n && we_n) |=> (drv == $past(drv) && q_r == $past(q_r))); // R8
  AST_WE_PULSE_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!cas_any && !we_n && we_q) |=> (drv == 2'b00)); // R10
  AST_LATE_OE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) ((wr_lane != 2'b00) && !start) |-> (mode_r == M_EW || oe_n)); // R7
  AST_HOLD_AT_RAS: assert property (@(posedge clk) disable iff (!rst_n) (!ras_n && ras_q && cas_any && cas_q) |=> (drv == $past(drv) && q_r == $past(q_r))); // R11
endmodule

// File: tb/dual_strobe_dram_ctl_tb.sv
module dual_strobe_dram_ctl_tb_top;
  logic clk = 0, rst_n = 0;
  logic ras_n = 1, casl_n = 1, cash_n = 1, we_n = 1, oe_n = 1;
  logic [3:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_en;
  int checks = 0, errs = 0;
  bit done = 0;
  logic [15:0] ref_mem [128];

  always #10 clk = ~clk;

  dual_strobe_dram_ctl dut_i (.clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n),
    .cash_n(cash_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_en(dq_en));

  function automatic logic [15:0] lmask(input logic [1:0] l);
    return {{8{l[1]}}, {8{l[0]}}};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] l);
    return (old & ~lmask(l)) | (nw & lmask(l));
  endfunction

  task automatic step(); @(posedge clk); #5; endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic lanes(input logic [1:0] l); casl_n = ~l[0]; cash_n = ~l[1]; endtask

  task automatic open_row(input int r); addr = 4'(r); ras_n = 0; step(); endtask

  task automatic close_row();
    ras_n = 1; lanes(2'b00); we_n = 1; oe_n = 1; step();
    chk("R9 closed row off", dq_en, 2'b00);
  endtask

  task automatic do_read(input int r, input int c, input logic [1:0] l);
    logic [15:0] e;
    e = ref_mem[r*8+c] & lmask(l);
    addr = 4'(c); we_n = 1; oe_n = 0; lanes(l); step();
    chk("R2/R3 read lanes", dq_en, l);
    chk("R2/R3 read data", dq_out & lmask(l), e);
    lanes(2'b00); step();
    chk("R8 edo lanes", dq_en, l);
    chk("R8 edo data", dq_out & lmask(l), e);
  endtask

  task automatic do_ew(input int r, input int c, input logic [1:0] l, input logic [15:0] d);
    addr = 4'(c); we_n = 0; oe_n = 0; dq_in = d; lanes(l); step();
    ref_mem[r*8+c] = merge(ref_mem[r*8+c], d, l);
    chk("R5 early write high-z", dq_en, 2'b00);
    lanes(2'b00); we_n = 1; oe_n = 1; step();
  endtask

  task automatic do_lw(input int r, input int c, input logic [1:0] l, input logic [15:0] d, input bit oe_low);
    logic [15:0] old;
    old = ref_mem[r*8+c] & lmask(l);
    addr = 4'(c); we_n = 1; oe_n = 0; lanes(l); step();
    chk("R6 pre-read", dq_out & lmask(l), old);
    oe_n = oe_low ? 1'b0 : 1'b1; step();
    we_n = 0; dq_in = d; step();
    if (oe_low) begin
      chk("R7 blocked write keeps lanes", dq_en, l);
      chk("R7 blocked write keeps data", dq_out & lmask(l), old);
    end else begin
      ref_mem[r*8+c] = merge(ref_mem[r*8+c], d, l);
      chk("R6 late write oe high off", dq_en, 2'b00);
    end
    lanes(2'b00); we_n = 1; oe_n = 1; step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed1234));
    step(); step(); rst_n = 1; step();
    chk("R9 reset off", dq_en, 2'b00);

    for (int r = 0; r < 16; r++) begin
      open_row(r);
      for (int c = 0; c < 8; c++) do_ew(r, c, 2'b11, 16'($urandom));
      close_row();
    end

    // R1: second lane joins; column is not relatched; re-fall does not start new access
    open_row(2);
    addr = 4'd1; we_n = 1; oe_n = 0; lanes(2'b01); step();
    chk("R1 lower only", dq_en, 2'b01);
    addr = 4'd5; lanes(2'b11); step();
    chk("R1 joined lanes", dq_en, 2'b11);
    chk("R1 upper from first column", dq_out, ref_mem[2*8+1]);
    cash_n = 1; step();
    addr = 4'd6; cash_n = 0; step();
    chk("R1 refall keeps column", dq_out, ref_mem[2*8+1]);
    close_row();

    // R9: oe high while strobes high turns off until next read
    open_row(5); do_read(5, 0, 2'b11);
    oe_n = 1; step(); oe_n = 0; step();
    chk("R9 oe pulse after cas off", dq_en, 2'b00);
    // R8: oe pulse while cas low returns same data
    addr = 4'd3; lanes(2'b11); step();
    oe_n = 1; step();
    chk("R8 oe high masks", dq_en, 2'b00);
    oe_n = 0; step();
    chk("R8 oe back same data", dq_out, ref_mem[5*8+3]);
    chk("R8 oe back lanes", dq_en, 2'b11);
    close_row();

    // R10: we pulse while cas high
    open_row(5); do_read(5, 1, 2'b11);
    we_n = 0; step(); we_n = 1; step();
    chk("R10 we pulse off", dq_en, 2'b00);
    do_read(5, 2, 2'b10);
    close_row();

    // R11: cas low at ras fall holds output
    open_row(3);
    addr = 4'd2; we_n = 1; oe_n = 0; lanes(2'b11); step();
    ras_n = 1; step();
    chk("R11 ras high cas low held", dq_en, 2'b11);
    addr = 4'd7; ras_n = 0; step(); step();
    chk("R11 hold lanes", dq_en, 2'b11);
    chk("R11 hold data", dq_out, ref_mem[3*8+2]);
    close_row();

    // R12: lane joins early write with we high; lane joins late write
    open_row(4);
    d = 16'($urandom);
    addr = 4'd3; we_n = 0; oe_n = 0; dq_in = d; lanes(2'b01); step();
    ref_mem[4*8+3] = merge(ref_mem[4*8+3], d, 2'b01);
    we_n = 1; dq_in = ~d; lanes(2'b11); step();
    chk("R12 ew join not driven", dq_en, 2'b00);
    lanes(2'b00); oe_n = 1; step();
    do_read(4, 3, 2'b11);
    lanes(2'b00); oe_n = 1; step();
    addr = 4'd4; we_n = 1; oe_n = 1; lanes(2'b01); step();
    d = 16'($urandom);
    we_n = 0; dq_in = d; step();
    ref_mem[4*8+4] = merge(ref_mem[4*8+4], d, 2'b01);
    dq_in = ~d; lanes(2'b11); step();
    lanes(2'b00); we_n = 1; step();
    do_read(4, 4, 2'b11);
    close_row();

    // R13: latency of one edge
    open_row(6);
    addr = 4'd0; we_n = 1; oe_n = 0; lanes(2'b11); #1;
    chk("R13 not before edge", dq_en, 2'b00);
    step();
    chk("R13 after edge", dq_en, 2'b11);
    close_row();

    // R6/R7 directed
    open_row(7);
    do_lw(7, 1, 2'b11, 16'hA5C3, 1'b0);
    do_lw(7, 2, 2'b10, 16'h3C5A, 1'b1);
    do_read(7, 1, 2'b11);
    do_read(7, 2, 2'b11);
    close_row();

    // Random mix (R2, R4, R6)
    for (int i = 0; i < 300; i++) begin
      int r, c, op;
      logic [1:0] l;
      r = $urandom_range(15); c = $urandom_range(7); op = $urandom_range(3);
      l = 2'($urandom_range(3, 1));
      open_row(r);
      case (op)
        0: do_read(r, c, l);
        1: do_ew(r, c, l, 16'($urandom));
        2: do_lw(r, c, l, 16'($urandom), 1'b0);
        default: do_lw(r, c, l, 16'($urandom), 1'b1);
      endcase
      do_read(r, c, 2'b11);
      close_row();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule